// File: doc/BRIEF.md
# Parallel Port Register Interface

This block is the byte-wide register file that sits between a host I/O bus and a legacy parallel printer port. One bus access names a 16-bit I/O address. The block checks whether the address falls inside its window and splits it into an offset. That offset selects one of five registers: output data, peripheral status, port control, enhanced-parallel address and enhanced-parallel data. Every other offset is inert. The block drives the data and control lines toward the pin side. It samples the status lines, the control lines and the data lines coming back from the peripheral. It also holds the port direction.

A level interrupt request is raised when the peripheral signals an acknowledge, provided interrupts are enabled in the control register. Any status read drops that request again. Enhanced-parallel address and data accesses are handed to an external bus engine. The handoff is a one-cycle strobe together with a flag that says whether the cycle is an address cycle or a data cycle. Handshake timing on the pins belongs to that engine.

Top module: `lpt_regfile`

## Requirements
- R1: The window starts at parameter BASE_ADDR (default 0x378) and spans 8 addresses, or 4 when BASE_ADDR is 0x3BC. The offset is the address minus the base. An access outside the window changes nothing and gives no rd_valid.
- R2: acc_size 0 means a single byte; any other code is wider. A wider write is dropped. A wider read returns rd_valid with rd_unused=1 and rd_data=0xFF.
- R3: Writes to offsets 5, 6 and 7 are ignored. Byte reads of those offsets return 0xFF with rd_unused=0.
- R4: A byte write to offset 0 latches the byte onto pd_out. A read of offset 0 returns the latched byte when pd_reverse is 0, and returns pd_in when pd_reverse is 1.
- R5: A control write (offset 2) first forces bits 7:6 to 1. If the result equals the stored control value, nothing changes, including the direction.
- R6: When a control write does take effect, bit 5 of the written byte sets pd_reverse (1 = reverse/input). The stored value, which is driven on ctl_out, has bit 5 cleared. Control bit 4 enables the interrupt.
- R7: A control read returns ctl_in with bits 7:6 forced to 1.
- R8: A status read (offset 1) returns st_in with bit 2 replaced by the current irq value.
- R9: irq rises on ack_evt only while stored control bit 4 is 1. A byte status read clears it. If both happen in the same cycle, the set wins.
- R10: A byte write to offset 3 or 4 places the byte on epp_wdata and pulses epp_wr_stb for one cycle. epp_is_addr is 1 for offset 3 and 0 for offset 4.
- R11: A byte read of offset 3 or 4 pulses epp_rd_stb with epp_is_addr set the same way as in R10, and returns epp_in as rd_data.
- R12: After reset, pd_out is 0x00, ctl_out is 0xC0, and pd_reverse, irq, both strobes and rd_valid are 0.
- R13: Every result is registered. It appears on the first clock edge after the access cycle, and rd_valid lasts exactly one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Bus access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | I/O address |
| acc_size | input | 2 | Access width code, 0 = byte |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |
| rd_unused | output | 1 | Read was wider than a byte |
| pd_out | output | 8 | Latched output data lines |
| pd_in | input | 8 | Sampled data lines |
| pd_reverse | output | 1 | Port direction, 1 = reverse |
| ctl_out | output | 8 | Stored control value driven to the lines |
| ctl_in | input | 8 | Sampled control lines |
| st_in | input | 8 | Sampled status lines |
| ack_evt | input | 1 | Peripheral acknowledge event pulse |
| irq | output | 1 | Level interrupt request |
| epp_wr_stb | output | 1 | Enhanced-parallel write strobe |
| epp_rd_stb | output | 1 | Enhanced-parallel read strobe |
| epp_is_addr | output | 1 | Strobe refers to an address cycle |
| epp_wdata | output | 8 | Enhanced-parallel write byte |
| epp_in | input | 8 | Enhanced-parallel sampled byte |

## Verification
Every result is due exactly one clock edge after the cycle in which the access, or the acknowledge event, is presented. That covers register outputs, direction, strobes, interrupt level and read responses. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from the same inputs, and outputs are compared on the next falling edge. A read answer is therefore judged in the single cycle where rd_valid is due. Directed checks follow each access task at that same falling edge. They cover the quirks: the equal-value control write that keeps the direction, a set and a clear of the interrupt in the same cycle, and the reduced window of a second instance placed at 0x3BC.

// File: rtl/lpt_pkg.sv
// Shared constants for the parallel port register file.
// Assumes byte registers and a 3-bit offset space.
package lpt_pkg;
    localparam int OFF_W = 3;
    localparam logic [OFF_W-1:0] OFF_DATA   = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STATUS = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd2;
    localparam logic [OFF_W-1:0] OFF_EADDR  = 3'd3;
    localparam logic [OFF_W-1:0] OFF_EDATA  = 3'd4;

    localparam int CTL_DIR_BIT   = 5;
    localparam int CTL_IRQEN_BIT = 4;
    localparam int STS_IRQ_BIT   = 2;
    localparam logic [7:0] CTL_RSV_ONES  = 8'hC0;
    localparam logic [7:0] BYTE_NODATA   = 8'hFF;
    localparam logic [1:0] SIZE_BYTE     = 2'd0;
endpackage

// File: rtl/lpt_decode.sv
// Address window decode.
// Produces a byte-write select, a read select, a wide-read flag and the offset.
// Assumes the window is 4 ports at base 0x3BC, otherwise 8.
module lpt_decode #(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h378
) (
    input  logic                     acc_en,
    input  logic                     acc_wr,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [1:0]               acc_size,
    output logic                     sel_wr,
    output logic                     sel_rd,
    output logic                     rd_wide,
    output logic [lpt_pkg::OFF_W-1:0] off
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
    localparam int NPORTS = (BASE_ADDR == 'h3BC) ? 4 : 8;
    localparam logic [ADDR_W-1:0] NPORTS_V = ADDR_W'(NPORTS);

    logic [ADDR_W-1:0] diff;
    logic              in_win;

    // Window hit and offset extraction.
    always_comb begin
        diff    = acc_addr - BASE_V;
        in_win  = acc_en && (acc_addr >= BASE_V) && (diff < NPORTS_V);
        off     = diff[lpt_pkg::OFF_W-1:0];
        sel_wr  = in_win && acc_wr && (acc_size == lpt_pkg::SIZE_BYTE);
        sel_rd  = in_win && !acc_wr;
        rd_wide = acc_size != lpt_pkg::SIZE_BYTE;
    end
endmodule

// File: rtl/lpt_ctrl_reg.sv
// Control register with the direction bit split out.
// A write forces bits 7:6 high and is discarded when it equals the stored value.
// Bit 5 goes to the direction flop and is never stored.
module lpt_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_q,
    output logic       dir_rev
);
    import lpt_pkg::*;

    logic [7:0] forced;
    logic       changed;

    // Forced value and change detect.
    always_comb begin
        forced  = wdata | CTL_RSV_ONES;
        changed = wr_en && (forced != ctl_q);
    end

    // Register update on an effective write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= CTL_RSV_ONES;
            dir_rev <= 1'b0;
        end else if (changed) begin
            ctl_q   <= forced & ~(8'h01 << CTL_DIR_BIT);
            dir_rev <= forced[CTL_DIR_BIT];
        end
    end

    // R5: an equal-value write leaves the direction and control alone
    a_r5_equal_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wdata | CTL_RSV_ONES) == ctl_q)) |=> ($stable(dir_rev) && $stable(ctl_q)));

    // R6: an effective write takes the direction from bit 5 of the written byte
    a_r6_dir_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wdata | CTL_RSV_ONES) != ctl_q)) |=> (dir_rev == $past(wdata[CTL_DIR_BIT])));
endmodule

// File: rtl/lpt_irq.sv
// Level interrupt request.
// Set by an acknowledge event while enabled, cleared by a status read; set wins.
module lpt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_evt,
    input  logic enable,
    input  logic clr,
    output logic irq
);
    logic set_c;

    // Set condition.
    always_comb set_c = ack_evt && enable;

    // Request flop.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq <= 1'b0;
        else if (set_c) irq <= 1'b1;
        else if (clr)   irq <= 1'b0;
    end

    // R9: a rise needs an enabled acknowledge in the previous cycle
    a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ack_evt) && $past(enable)));

    // R9: a status read without a new event drops the request
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(ack_evt && enable)) |=> !irq);
endmodule

// File: rtl/lpt_regfile.sv
// Parallel port host register file, top level.
// Holds the data and enhanced-parallel registers and the registered read path.
// Assumes one access per cycle; all outputs are registered.
module lpt_regfile #(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h378
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [7:0]        acc_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              rd_unused,
    output logic [7:0]        pd_out,
    input  logic [7:0]        pd_in,
    output logic              pd_reverse,
    output logic [7:0]        ctl_out,
    input  logic [7:0]        ctl_in,
    input  logic [7:0]        st_in,
    input  logic              ack_evt,
    output logic              irq,
    output logic              epp_wr_stb,
    output logic              epp_rd_stb,
    output logic              epp_is_addr,
    output logic [7:0]        epp_wdata,
    input  logic [7:0]        epp_in
);
    import lpt_pkg::*;

    logic             sel_wr, sel_rd, rd_wide;
    logic [OFF_W-1:0] off;
    logic             ctl_wr, sts_rd, epp_wr, epp_rd;
    logic [7:0]       rd_mux;
    logic [7:0]       sts_view;

    lpt_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_size(acc_size),
        .sel_wr(sel_wr), .sel_rd(sel_rd), .rd_wide(rd_wide), .off(off)
    );

    // Per-register access selects.
    always_comb begin
        ctl_wr = sel_wr && (off == OFF_CTRL);
        sts_rd = sel_rd && !rd_wide && (off == OFF_STATUS);
        epp_wr = sel_wr && (off == OFF_EADDR || off == OFF_EDATA);
        epp_rd = sel_rd && !rd_wide && (off == OFF_EADDR || off == OFF_EDATA);
    end

    lpt_ctrl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wdata(acc_wdata),
        .ctl_q(ctl_out), .dir_rev(pd_reverse)
    );

    lpt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ack_evt(ack_evt), .enable(ctl_out[CTL_IRQEN_BIT]),
        .clr(sts_rd), .irq(irq)
    );

    // Read value selection.
    always_comb begin
        sts_view = st_in;
        sts_view[STS_IRQ_BIT] = irq;
        if (rd_wide) rd_mux = BYTE_NODATA;
        else begin
            case (off)
                OFF_DATA:   rd_mux = pd_reverse ? pd_in : pd_out;
                OFF_STATUS: rd_mux = sts_view;
                OFF_CTRL:   rd_mux = ctl_in | CTL_RSV_ONES;
                OFF_EADDR,
                OFF_EDATA:  rd_mux = epp_in;
                default:    rd_mux = BYTE_NODATA;
            endcase
        end
    end

    // Data latch, enhanced-parallel handoff and read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_out      <= 8'h00;
            rd_valid    <= 1'b0;
            rd_data     <= 8'h00;
            rd_unused   <= 1'b0;
            epp_wr_stb  <= 1'b0;
            epp_rd_stb  <= 1'b0;
            epp_is_addr <= 1'b0;
            epp_wdata   <= 8'h00;
        end else begin
            rd_valid   <= sel_rd;
            epp_wr_stb <= epp_wr;
            epp_rd_stb <= epp_rd;
            if (sel_wr && off == OFF_DATA) pd_out <= acc_wdata;
            if (sel_rd) begin
                rd_data   <= rd_mux;
                rd_unused <= rd_wide;
            end
            if (epp_wr) epp_wdata <= acc_wdata;
            if (epp_wr || epp_rd) epp_is_addr <= (off == OFF_EADDR);
        end
    end

    // R2: a wide write touches neither data, control nor the handoff
    a_r2_wide_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_size != SIZE_BYTE) |=>
        ($stable(pd_out) && $stable(ctl_out) && !epp_wr_stb));

    // R10: write and read strobes never overlap
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(epp_wr_stb && epp_rd_stb));
endmodule

// File: tb/lpt_regfile_bench.sv
module lpt_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 'h378;

    logic clk = 0, rst_n = 0;
    logic acc_en = 0, acc_wr = 0, ack_evt = 0;
    logic [15:0] acc_addr = 0;
    logic [1:0] acc_size = 0;
    logic [7:0] acc_wdata = 0, pd_in = 0, ctl_in = 0, st_in = 0, epp_in = 0;
    logic rd_valid, rd_unused, pd_reverse, irq, epp_wr_stb, epp_rd_stb, epp_is_addr;
    logic [7:0] rd_data, pd_out, ctl_out, epp_wdata;
    logic b_rv, b_ru, b_rev, b_irq, b_ws, b_rs, b_ia;
    logic [7:0] b_rd, b_pd, b_ctl, b_ew;

    int tests = 0, fails = 0;
    bit running = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpt_regfile u_lpt_regfile (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_unused(rd_unused), .pd_out(pd_out), .pd_in(pd_in), .pd_reverse(pd_reverse),
        .ctl_out(ctl_out), .ctl_in(ctl_in), .st_in(st_in), .ack_evt(ack_evt), .irq(irq),
        .epp_wr_stb(epp_wr_stb), .epp_rd_stb(epp_rd_stb), .epp_is_addr(epp_is_addr),
        .epp_wdata(epp_wdata), .epp_in(epp_in));

    lpt_regfile #(.BASE_ADDR('h3BC)) u_alt (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .rd_valid(b_rv), .rd_data(b_rd),
        .rd_unused(b_ru), .pd_out(b_pd), .pd_in(pd_in), .pd_reverse(b_rev),
        .ctl_out(b_ctl), .ctl_in(ctl_in), .st_in(st_in), .ack_evt(ack_evt), .irq(b_irq),
        .epp_wr_stb(b_ws), .epp_rd_stb(b_rs), .epp_is_addr(b_ia),
        .epp_wdata(b_ew), .epp_in(epp_in));

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_pd, m_ctl, m_rev, m_irq, m_rv, m_rd, m_ru, m_ws, m_rs, m_ia, m_ew;
    string m_tag;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pd = 0; m_ctl = 'hC0; m_rev = 0; m_irq = 0; m_rv = 0; m_rd = 0; m_ru = 0;
            m_ws = 0; m_rs = 0; m_ia = 0; m_ew = 0; m_tag = "R12";
        end else begin
            int a, o, byt, hit, irq_old, nirq, v;
            a = int'(acc_addr);
            hit = acc_en && a >= BASE && a < BASE + 8;
            o = a - BASE;
            byt = (acc_size == 0);
            irq_old = m_irq;
            nirq = m_irq;
            m_rv = 0; m_ws = 0; m_rs = 0;
            if (hit && acc_wr && byt) begin
                if (o == 0) m_pd = acc_wdata;
                if (o == 2) begin
                    v = acc_wdata | 'hC0;
                    if (v != m_ctl) begin m_rev = (v >> 5) & 1; m_ctl = v & 'hDF; end
                end
                if (o == 3 || o == 4) begin m_ws = 1; m_ia = (o == 3); m_ew = acc_wdata; end
            end
            if (hit && !acc_wr) begin
                m_rv = 1; m_ru = !byt;
                if (!byt) begin m_rd = 'hFF; m_tag = "R2"; end
                else if (o == 0) begin m_rd = m_rev ? pd_in : m_pd; m_tag = "R4"; end
                else if (o == 1) begin
                    m_rd = (st_in & 'hFB) | (irq_old << 2); m_tag = "R8"; nirq = 0;
                end
                else if (o == 2) begin m_rd = ctl_in | 'hC0; m_tag = "R7"; end
                else if (o == 3 || o == 4) begin
                    m_rd = epp_in; m_rs = 1; m_ia = (o == 3); m_tag = "R11";
                end
                else begin m_rd = 'hFF; m_tag = "R3"; end
            end
            if (ack_evt && ((m_ctl_prev() >> 4) & 1)) nirq = 1;
            m_irq = nirq;
        end
    end
    int m_ctl_q = 'hC0;
    function automatic int m_ctl_prev(); return m_ctl_q; endfunction
    always @(negedge clk) m_ctl_q = m_ctl;

    // Compare on every clock, away from the rising edge
    always @(negedge clk) if (running) begin
        chk("R4 pd_out", pd_out, m_pd);
        chk("R6 ctl_out", ctl_out, m_ctl);
        chk("R6 pd_reverse", pd_reverse, m_rev);
        chk("R9 irq", irq, m_irq);
        chk("R10 epp_wr_stb", epp_wr_stb, m_ws);
        chk("R11 epp_rd_stb", epp_rd_stb, m_rs);
        chk("R13 rd_valid", rd_valid, m_rv);
        if (m_ws || m_rs) chk("R10 epp_is_addr", epp_is_addr, m_ia);
        if (m_ws) chk("R10 epp_wdata", epp_wdata, m_ew);
        if (m_rv) begin
            chk({m_tag, " rd_data"}, rd_data, m_rd);
            chk({m_tag, " rd_unused"}, rd_unused, m_ru);
        end
    end

    task automatic access(input bit wr, input int addr, input int size, input int wd);
        @(negedge clk);
        acc_en = 1; acc_wr = wr; acc_addr = addr[15:0]; acc_size = size[1:0]; acc_wdata = wd[7:0];
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R12 pd_out", pd_out, 0); chk("R12 ctl_out", ctl_out, 'hC0);
        chk("R12 irq", irq, 0); chk("R12 rd_valid", rd_valid, 0);
        chk("R12 pd_reverse", pd_reverse, 0);
        running = 1;
        st_in = 8'hA7; ctl_in = 8'h15; epp_in = 8'h5E; pd_in = 8'h3C;

        access(1, BASE + 0, 0, 'hA5);
        chk("R4 latch", pd_out, 'hA5);
        access(0, BASE + 0, 0, 0);
        chk("R4 forward read", rd_data, 'hA5);

        access(1, BASE + 2, 0, 'h10);
        chk("R5 forced ones", ctl_out, 'hD0);
        @(negedge clk); ack_evt = 1; @(negedge clk); ack_evt = 0;
        chk("R9 set", irq, 1);
        access(0, BASE + 1, 0, 0);
        chk("R8 status irq bit", rd_data, 'hA7);
        chk("R9 cleared", irq, 0);

        ack_evt = 1;
        access(0, BASE + 1, 0, 0);
        ack_evt = 0;
        chk("R9 set wins", irq, 1);
        access(0, BASE + 1, 0, 0);
        chk("R9 clear again", irq, 0);

        access(1, BASE + 2, 0, 'h30);
        chk("R6 reverse", pd_reverse, 1);
        chk("R6 bit5 not stored", ctl_out, 'hD0);
        access(0, BASE + 0, 0, 0);
        chk("R4 reverse read", rd_data, 'h3C);
        access(1, BASE + 2, 0, 'h10);
        chk("R5 equal write keeps dir", pd_reverse, 1);
        access(1, BASE + 2, 0, 'h00);
        chk("R6 forward", pd_reverse, 0);
        chk("R6 ctl", ctl_out, 'hC0);
        access(0, BASE + 2, 0, 0);
        chk("R7 ctl read", rd_data, 'hD5);
        @(negedge clk); ack_evt = 1; @(negedge clk); ack_evt = 0;
        chk("R9 disabled", irq, 0);

        access(1, BASE + 3, 0, 'h12);
        access(1, BASE + 4, 0, 'h34);
        access(0, BASE + 3, 0, 0);
        chk("R11 epp addr read", rd_data, 'h5E);
        access(0, BASE + 4, 0, 0);

        access(1, BASE + 5, 0, 'h77);
        access(0, BASE + 6, 0, 0);
        chk("R3 unused offset", rd_data, 'hFF);
        access(1, BASE + 0, 1, 'h11);
        chk("R2 wide write dropped", pd_out, 'hA5);
        access(0, BASE + 0, 2, 0);
        chk("R2 wide read unused", rd_unused, 1);

        access(0, BASE + 8, 0, 0);
        chk("R1 outside window", rd_valid, 0);
        access(1, 'h3BF, 0, 'h42);
        chk("R1 alt base offset3", b_ws, 1);
        access(1, 'h3C0, 0, 'h42);
        chk("R1 alt base 4 ports", b_ws, 0);

        repeat (3) @(negedge clk);
        running = 0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule